// File: doc/BRIEF.md
# Duty-Limited Bridge PWM Modulator

This block turns one signed audio sample per channel into gate commands for two full-bridge output stages. Each bridge has two half-bridges, and each half-bridge gets a high-side and a low-side command. A free-running counter sets the carrier period. The positive half-bridge is pushed up from 50% duty by the sample, and the negative half-bridge is pushed down by the same amount, so a zero sample gives no differential output.

A limit code caps the modulation depth. The cap is a ceiling on how far the duty cycle may move from 50%, and it is the same in both directions. The signal is clipped, not scaled. The all-ones limit code turns the ceiling off. A programmable dead time keeps both switches of a half-bridge off for a few clocks at every changeover.

A mode input fuses the two bridges into one mono output driven from the right-channel sample. A mute input puts every output into high impedance at once. An enable input stops the carrier. Samples, limit code, dead time and mode are all captured only at carrier period boundaries. The carrier period is 2^SW clocks, so the default SW=8 gives about 260 kHz from a 66.6 MHz clock.

Top module: `bpwm_modulator`

## Requirements
- R1: The carrier period is 2^SW clocks. With H = 2^(SW-1) and a clamped sample c, the positive half-bridge wants its high side for H+c cycles of each period and the negative half-bridge for H-c cycles. A zero sample therefore gives 50% on both. Duty 0 holds the low side for the whole period, and duty 2^SW holds the high side for the whole period.
- R2: The clamp ceiling equals the unsigned limit code (SW-1 bits), and the sample is clipped to the range from minus the ceiling to plus the ceiling. When the limit code is all ones, no clamp is applied.
- R3: With latched dead time D, each high-side pulse is D cycles shorter than the wanted high time and each low-side pulse is D cycles shorter than the wanted low time. A pulse of D cycles or fewer disappears. A high and a low command for the same half-bridge are never on together.
- R4: When the mode input is low, the left bridge (index 0 positive, index 1 negative) follows only the left sample, and the right bridge (index 2 positive, index 3 negative) follows only the right sample.
- R5: When the mode input is high, both right half-bridges (indices 2 and 3) follow the positive duty of the right sample, and both left half-bridges (indices 0 and 1) follow the negative duty of the right sample. The left sample has no effect in this mode.
- R6: While mute is high, all high and low commands are 0 and both tristate flags are 1 in the same cycle. Switching resumes when mute is released.
- R7: While enable is low, all commands are 0, both tristate flags are 1, and the carrier is held at its start. Switching returns when enable is raised again.
- R8: Samples, limit code, dead time and mode are captured only at the end of a carrier period. A high pulse already in progress keeps its old length.
- R9: During reset, all commands are 0 and both tristate flags are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the carrier when high |
| mute | input | 1 | Forces all outputs to high impedance at once |
| monoMode | input | 1 | High fuses both bridges into one mono output |
| sampleL | input | SW | Left sample, two's complement |
| sampleR | input | SW | Right sample, two's complement |
| limitCode | input | SW-1 | Modulation ceiling; all ones means no limit |
| deadTime | input | DW | Dead time in clocks |
| hiDrv | output | 4 | High-side commands: 0 L+, 1 L-, 2 R+, 3 R- |
| loDrv | output | 4 | Low-side commands, same indexing |
| hiZ | output | 2 | Tristate flag per bridge: 0 left, 1 right |

## Verification
The bench builds the block with SW=6 and DW=3. This gives a 64-clock carrier, so every sample code can be swept, every dead time from 0 to 7 can be tried, and the clamp can be tested at both ends and in between. The bench counts high and low cycles over a full period for each half-bridge and compares them with the duty arithmetic. The mono mode, mute and enable are checked the same way. A separate test changes the sample in the middle of a pulse to check that new values are only captured at the period boundary.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic run;   // carrier active
    logic load;  // capture new inputs this edge
  } bpwm_stb_t;
endpackage

// File: rtl/bpwm_halfbridge.sv
module bpwm_halfbridge #(
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          run,
  input  logic          want,
  input  logic [DW-1:0] deadTime,
  output logic          hi,
  output logic          lo
);
  logic          level;
  logic [DW-1:0] deadCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level   <= 1'b0;
      deadCnt <= '0;
    end else if (!run) begin
      level   <= 1'b0;
      deadCnt <= '0;
    end else if (want != level) begin
      level   <= want;
      deadCnt <= deadTime;
    end else if (deadCnt != '0) begin
      deadCnt <= deadCnt - DW'(1);
    end
  end

  assign hi = level  && (deadCnt == '0);
  assign lo = !level && (deadCnt == '0);
endmodule

// File: rtl/bpwm_ctrl.sv
module bpwm_ctrl
  import bpwm_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  output logic [SW-1:0] phase,
  output bpwm_stb_t     stb
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        phase <= '0;
    else if (!enable) phase <= '0;
    else              phase <= phase + SW'(1);
  end

  // capture continuously while stopped, else at the last count of a period
  always_comb begin
    stb.run  = enable;
    stb.load = !enable || (phase == '1);
  end
endmodule

// File: rtl/bpwm_datapath.sv
module bpwm_datapath
  import bpwm_pkg::*;
#(
  parameter int SW = 8,
  parameter int DW = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bpwm_stb_t            stb,
  input  logic [SW-1:0]        phase,
  input  logic signed [SW-1:0] sampleL,
  input  logic signed [SW-1:0] sampleR,
  input  logic [SW-2:0]        limitCode,
  input  logic [DW-1:0]        deadTime,
  input  logic                 monoMode,
  output logic [3:0]           rawHi,
  output logic [3:0]           rawLo
);
  localparam int LW     = SW - 1;
  localparam int HALF   = 1 << (SW - 1);
  localparam int DUTY_W = SW + 1;
  localparam int EXT_W  = SW + 2;

  logic signed [SW-1:0] sampL, sampR;
  logic [LW-1:0]        lim;
  logic [DW-1:0]        dead;
  logic                 mono;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampL <= '0;
      sampR <= '0;
      lim   <= '1;
      dead  <= '0;
      mono  <= 1'b0;
    end else if (stb.load) begin
      sampL <= sampleL;
      sampR <= sampleR;
      lim   <= limitCode;
      dead  <= deadTime;
      mono  <= monoMode;
    end
  end

  // symmetric clip to the ceiling, then offset from half period
  function automatic logic [DUTY_W-1:0] clampDuty(
    input logic signed [SW-1:0] s,
    input logic [LW-1:0]        l,
    input logic                 pos
  );
    logic signed [EXT_W-1:0] sx, ceilX, cx, dx, halfX;
    halfX = EXT_W'(HALF);
    sx    = {{2{s[SW-1]}}, s};
    if (&l) ceilX = halfX;
    else    ceilX = {3'b000, l};
    cx = sx;
    if (sx > ceilX)       cx = ceilX;
    else if (sx < -ceilX) cx = -ceilX;
    dx = pos ? (halfX + cx) : (halfX - cx);
    return dx[DUTY_W-1:0];
  endfunction

  logic [DUTY_W-1:0] dutyPL, dutyNL, dutyPR, dutyNR;
  logic [DUTY_W-1:0] duty [4];
  logic [3:0]        want;

  always_comb begin
    dutyPL = clampDuty(sampL, lim, 1'b1);
    dutyNL = clampDuty(sampL, lim, 1'b0);
    dutyPR = clampDuty(sampR, lim, 1'b1);
    dutyNR = clampDuty(sampR, lim, 1'b0);
    if (mono) begin
      duty[0] = dutyNR;
      duty[1] = dutyNR;
      duty[2] = dutyPR;
      duty[3] = dutyPR;
    end else begin
      duty[0] = dutyPL;
      duty[1] = dutyNL;
      duty[2] = dutyPR;
      duty[3] = dutyNR;
    end
  end

  for (genvar i = 0; i < 4; i++) begin : gHalf
    assign want[i] = {1'b0, phase} < duty[i];
    bpwm_halfbridge #(.DW(DW)) uHb (
      .clk      (clk),
      .rstN     (rstN),
      .run      (stb.run),
      .want     (want[i]),
      .deadTime (dead),
      .hi       (rawHi[i]),
      .lo       (rawLo[i])
    );
  end
endmodule

// File: rtl/bpwm_modulator.sv
module bpwm_modulator
  import bpwm_pkg::*;
#(
  parameter int SW = 8,
  parameter int DW = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 mute,
  input  logic                 monoMode,
  input  logic signed [SW-1:0] sampleL,
  input  logic signed [SW-1:0] sampleR,
  input  logic [SW-2:0]        limitCode,
  input  logic [DW-1:0]        deadTime,
  output logic [3:0]           hiDrv,
  output logic [3:0]           loDrv,
  output logic [1:0]           hiZ
);
  logic [SW-1:0] phase;
  bpwm_stb_t     stb;
  logic [3:0]    rawHi, rawLo;
  logic          drive;

  bpwm_ctrl #(.SW(SW)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .phase  (phase),
    .stb    (stb)
  );

  bpwm_datapath #(.SW(SW), .DW(DW)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .phase     (phase),
    .sampleL   (sampleL),
    .sampleR   (sampleR),
    .limitCode (limitCode),
    .deadTime  (deadTime),
    .monoMode  (monoMode),
    .rawHi     (rawHi),
    .rawLo     (rawLo)
  );

  assign drive = rstN && enable && !mute;
  assign hiDrv = rawHi & {4{drive}};
  assign loDrv = rawLo & {4{drive}};
  assign hiZ   = {2{!drive}};
endmodule

// File: rtl/bpwm_checker.sv
module bpwm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       mute,
  input logic [3:0] hiDrv,
  input logic [3:0] loDrv,
  input logic [1:0] hiZ
);
  assert_no_shoot_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hiDrv & loDrv) == 4'b0000);

  assert_mute_hiz_R6: assert property (@(posedge clk) disable iff (!rstN)
    mute |-> (hiDrv == 4'b0000 && loDrv == 4'b0000 && hiZ == 2'b11));

  assert_disable_hiz_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (hiDrv == 4'b0000 && loDrv == 4'b0000 && hiZ == 2'b11));

  assert_drive_active_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((hiDrv | loDrv) != 4'b0000) |-> (hiZ == 2'b00 && enable && !mute));

  assert_bridge_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hiZ ^ {hiZ[0], hiZ[1]}) && (hiZ[0] == hiZ[1]));
endmodule

bind bpwm_modulator bpwm_checker uChk (
  .clk    (clk),
  .rstN   (rstN),
  .enable (enable),
  .mute   (mute),
  .hiDrv  (hiDrv),
  .loDrv  (loDrv),
  .hiZ    (hiZ)
);

// File: tb/tb_bpwm_modulator.sv
module tb_bpwm_modulator;
  localparam int SW = 6;
  localparam int DW = 3;
  localparam int P  = 1 << SW;
  localparam int H  = P / 2;

  logic clk = 1'b0;
  logic rstN, enable, mute, monoMode;
  logic signed [SW-1:0] sampleL, sampleR;
  logic [SW-2:0] limitCode;
  logic [DW-1:0] deadTime;
  logic [3:0] hiDrv, loDrv;
  logic [1:0] hiZ;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bpwm_modulator #(.SW(SW), .DW(DW)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .mute(mute), .monoMode(monoMode),
    .sampleL(sampleL), .sampleR(sampleR), .limitCode(limitCode),
    .deadTime(deadTime), .hiDrv(hiDrv), .loDrv(loDrv), .hiZ(hiZ)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dutyOf(input int s, input int lim, input bit pos);
    int c;
    int ceilv;
    ceilv = (lim == H - 1) ? H : lim;
    c = s;
    if (c > ceilv) c = ceilv;
    if (c < -ceilv) c = -ceilv;
    return pos ? H + c : H - c;
  endfunction

  function automatic int expHi(input int d, input int dt);
    if (d == 0) return 0;
    if (d == P) return P;
    return (d > dt) ? d - dt : 0;
  endfunction

  function automatic int expLo(input int d, input int dt);
    if (d == 0) return P;
    if (d == P) return 0;
    return (P - d > dt) ? P - d - dt : 0;
  endfunction

  task automatic setIn(input int sL, input int sR, input int lim, input int dt, input bit mono);
    @(negedge clk);
    sampleL   = SW'(sL);
    sampleR   = SW'(sR);
    limitCode = (SW-1)'(lim);
    deadTime  = DW'(dt);
    monoMode  = mono;
  endtask

  // settle three periods, count one full period, compare with duty arithmetic
  task automatic measure(input int sL, input int sR, input int lim, input int dt,
                         input bit mono, input string req);
    int hc[4];
    int lc[4];
    int d[4];
    for (int i = 0; i < 4; i++) begin hc[i] = 0; lc[i] = 0; end
    repeat (3 * P) @(negedge clk);
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        hc[i] += int'(hiDrv[i]);
        lc[i] += int'(loDrv[i]);
      end
    end
    if (mono) begin
      d[0] = dutyOf(sR, lim, 0); d[1] = d[0];
      d[2] = dutyOf(sR, lim, 1); d[3] = d[2];
    end else begin
      d[0] = dutyOf(sL, lim, 1); d[1] = dutyOf(sL, lim, 0);
      d[2] = dutyOf(sR, lim, 1); d[3] = dutyOf(sR, lim, 0);
    end
    for (int i = 0; i < 4; i++) begin
      chk(hc[i] == expHi(d[i], dt), req, hc[i], expHi(d[i], dt));
      chk(lc[i] == expLo(d[i], dt), req, lc[i], expLo(d[i], dt));
    end
  endtask

  task automatic run(input int sL, input int sR, input int lim, input int dt,
                     input bit mono, input string req);
    setIn(sL, sR, lim, dt, mono);
    measure(sL, sR, lim, dt, mono, req);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lims[6];
    int smp[7];
    int run1;
    rstN = 0; enable = 0; mute = 0; monoMode = 0;
    sampleL = '0; sampleR = '0; limitCode = '1; deadTime = '0;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(hiDrv == 0 && loDrv == 0, "R9 reset drives", int'({hiDrv, loDrv}), 0);
    chk(hiZ == 2'b11, "R9 reset tristate", int'(hiZ), 3);
    rstN = 1;
    @(negedge clk);
    enable = 1;

    // R1 R4: full sample sweep, stereo, no limit, dead 2
    for (int s = -H; s < H; s++) run(s, -s - 1, H - 1, 2, 0, "R1 R4 stereo sweep");

    // R2: clamp ceilings
    lims = '{0, 1, 5, 17, 30, 31};
    smp  = '{-32, -20, -1, 0, 1, 19, 31};
    foreach (lims[a]) foreach (smp[b])
      run(smp[b], -smp[b] / 2, lims[a], 2, 0, "R2 clamp");

    // R3: dead time sweep
    for (int dt = 0; dt < 8; dt++) begin
      run(0, 10, H - 1, dt, 0, "R3 dead time");
      run(-31, 31, H - 1, dt, 0, "R3 dead time");
      run(-32, 29, H - 1, dt, 0, "R3 dead time");
    end

    // R5: mono, left sample differs and must not matter
    for (int s = -H; s < H; s += 5) run(17, s, H - 1, 2, 1, "R5 mono");
    run(-9, 25, 12, 1, 1, "R5 mono clamp");

    // R6: mute
    run(10, -7, H - 1, 2, 0, "R4 stereo");
    @(negedge clk);
    mute = 1;
    #1;
    chk(hiDrv == 0 && loDrv == 0, "R6 mute drives", int'({hiDrv, loDrv}), 0);
    chk(hiZ == 2'b11, "R6 mute tristate", int'(hiZ), 3);
    repeat (P) @(negedge clk);
    chk(hiDrv == 0 && loDrv == 0 && hiZ == 2'b11, "R6 mute held", int'(hiZ), 3);
    mute = 0;
    measure(10, -7, H - 1, 2, 0, "R6 resume");

    // R7: enable low
    @(negedge clk);
    enable = 0;
    #1;
    chk(hiDrv == 0 && loDrv == 0, "R7 disabled drives", int'({hiDrv, loDrv}), 0);
    chk(hiZ == 2'b11, "R7 disabled tristate", int'(hiZ), 3);
    repeat (P + 5) @(negedge clk);
    chk(hiDrv == 0 && loDrv == 0 && hiZ == 2'b11, "R7 disabled held", int'(hiZ), 3);
    enable = 1;
    measure(10, -7, H - 1, 2, 0, "R7 re-enable");

    // R8: change sample mid-pulse; running pulse keeps its length
    run(16, 0, H - 1, 2, 0, "R8 setup");
    while (hiDrv[0]) @(negedge clk);
    while (!hiDrv[0]) @(negedge clk);
    run1 = 0;
    for (int k = 0; k < 3; k++) begin run1++; @(negedge clk); end
    sampleL = SW'(-20);
    while (hiDrv[0]) begin run1++; @(negedge clk); end
    chk(run1 == H + 16 - 2, "R8 pulse kept", run1, H + 16 - 2);
    while (!hiDrv[0]) @(negedge clk);
    run1 = 0;
    while (hiDrv[0]) begin run1++; @(negedge clk); end
    chk(run1 == H - 20 - 2, "R8 next pulse", run1, H - 20 - 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule